// File: doc/BRIEF.md
# Delta-Panel Horizontal Drive Timing Generator

This block produces the horizontal drive waveforms for a TFT panel whose pixels sit in a delta arrangement and whose column shift register can run in either direction. Each time the line-start strobe is sampled high, the block latches the aspect and scan-direction inputs and flips the line polarity flag. After a programmable lead time it raises the horizontal start pulse for half a shift-clock period. It then emits a burst of complementary shift-clock pairs and returns to blanking. On lines with the polarity flag set, the start pulse and the whole burst move 1.5 shift-clock periods later, which matches the 1.5-dot stagger between neighbouring rows of the delta layout. The burst is long in wide (16:9) mode and short in narrow (4:3) mode.

The system clock runs at `2*HALF_CYC` times the shift-clock rate. With the default `HALF_CYC = 2`, the setup window and the delta offset are whole numbers of system cycles (2 and 6). Timing is counted in system clock edges. The edge that samples `line_start_i` high is edge 0, and "after edge j" means the register outputs that settle after that edge. The lead `LEAD_CYC` is the number of edges from edge 0 to the first rise of `hclk_a_o` on an unshifted line. The polarity flag is 0 after reset and is 1 on the first line.

The sequencer has four named states. IDLE (blanking) moves to WAIT on a line strobe. WAIT counts down the lead and then moves to SETUP. SETUP holds the start pulse for `HALF_CYC` cycles and then moves to BURST. BURST runs the clock pairs and moves to IDLE after the last pulse. A line strobe in any state forces WAIT.

Top module: `delta_htiming`

## Requirements
- R1: Reset state: `hstart_o`=0, `hclk_a_o`=0, `hclk_b_o`=1, `hblank_o`=1, `vid_inv_o`=0, `aspect_wide_o`=1, `scan_fwd_o`=1.
- R2: `hclk_b_o` is always the inverse of `hclk_a_o`. While blanking, `hclk_a_o` is low and `hclk_b_o` is high.
- R3: `hstart_o` is high exactly after edges k-HALF_CYC to k-1, where edge k is the edge after which `hclk_a_o` first rises. It falls on the same edge that raises `hclk_a_o` and is only ever high during blanking.
- R4: The first rise of `hclk_a_o` comes after edge k = `LEAD_CYC` when `vid_inv_o` is 0 for the line, and after edge k = `LEAD_CYC + 3*HALF_CYC` when it is 1.
- R5: In wide mode (`aspect_wide_i`=1 at the strobe) the burst has `NUM_WIDE` pulses. Each pulse is high for `HALF_CYC` cycles and low for `HALF_CYC` cycles.
- R6: In narrow mode (`aspect_wide_i`=0 at the strobe) the burst has `NUM_NARROW` pulses with the same shape.
- R7: `vid_inv_o` toggles after every edge that samples `line_start_i` high, and holds its value otherwise.
- R8: The mode inputs are latched only at the strobe. A change during a line does not alter the burst or `aspect_wide_o`/`scan_fwd_o`, which show the latched values (1 = wide, 1 = forward scan).
- R9: A strobe in the middle of a burst abandons that burst. From edge 1 of the new line onward, outputs follow the new line's timing.
- R10: `hblank_o` is low exactly after edges k to k+2*HALF_CYC*N-1, where N is the burst length, and high at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 2*HALF_CYC times the shift-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | One-cycle line-start strobe |
| aspect_wide_i | input | 1 | 1 selects 16:9, 0 selects 4:3 |
| scan_fwd_i | input | 1 | 1 selects forward scan, 0 selects reverse |
| hstart_o | output | 1 | Horizontal start pulse |
| hclk_a_o | output | 1 | Shift clock, phase A |
| hclk_b_o | output | 1 | Shift clock, phase B (complement of A) |
| hblank_o | output | 1 | High outside the clock burst |
| vid_inv_o | output | 1 | Line polarity flag; 1 also selects the delayed start |
| aspect_wide_o | output | 1 | Latched aspect mode for the panel |
| scan_fwd_o | output | 1 | Latched scan direction for the panel |

## Verification
The bench builds the block with `HALF_CYC=2`, `LEAD_CYC=5`, `NUM_WIDE=7` and `NUM_NARROW=4`. That keeps the real 4:1 clock ratio, the 2-cycle setup and the 6-cycle delta offset, but a whole line fits in 44 cycles. With lines that short, every combination of aspect, direction and line parity can be compared cycle by cycle against arithmetic expectations for start position, pulse shape and burst end. The same configuration also reaches a mode change in the middle of a line and a strobe that cuts into a running burst.

// File: rtl/htg_pkg.sv
package htg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SETUP = 2'd2,
        ST_BURST = 2'd3
    } htg_state_t;

    typedef struct packed {
        logic hstart;
        logic hclk;
        logic blank;
    } htg_drive_t;

endpackage

// File: rtl/htg_line_ctl.sv
// Per-line control: latches the mode inputs on the strobe and keeps line parity.
module htg_line_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start_i,
    input  logic aspect_wide_i,
    input  logic scan_fwd_i,
    output logic wide_o,
    output logic fwd_o,
    output logic odd_o,
    output logic odd_next_o
);

    logic wide_q;
    logic fwd_q;
    logic odd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q <= 1'b1;
            fwd_q  <= 1'b1;
            odd_q  <= 1'b0;
        end else if (line_start_i) begin
            wide_q <= aspect_wide_i;
            fwd_q  <= scan_fwd_i;
            odd_q  <= ~odd_q;
        end
    end

    // parity the line being started will carry
    assign odd_next_o = odd_q ^ line_start_i;
    assign wide_o     = wide_q;
    assign fwd_o      = fwd_q;
    assign odd_o      = odd_q;

endmodule

// File: rtl/htg_seq_fsm.sv
// Line sequencer: IDLE -> WAIT -> SETUP -> BURST -> IDLE, restarted by any strobe.
module htg_seq_fsm
    import htg_pkg::*;
#(
    parameter int HALF_CYC   = 2,
    parameter int LEAD_CYC   = 6,
    parameter int NUM_WIDE   = 357,
    parameter int NUM_NARROW = 268
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start_i,
    input  logic       odd_next_i,
    input  logic       wide_i,
    output htg_drive_t drive_o
);

    localparam int PERIOD    = 2 * HALF_CYC;
    localparam int DELTA     = 3 * HALF_CYC;
    localparam int WAIT_EVEN = LEAD_CYC - 2 - HALF_CYC;
    localparam int WAIT_ODD  = WAIT_EVEN + DELTA;
    localparam int NUM_MAX   = (NUM_WIDE > NUM_NARROW) ? NUM_WIDE : NUM_NARROW;
    localparam int TW        = (WAIT_ODD > 1) ? $clog2(WAIT_ODD + 1) : 1;
    localparam int PW        = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int CW        = (NUM_MAX > 1) ? $clog2(NUM_MAX) : 1;

    htg_state_t      state_q, state_nx;
    logic [TW-1:0]   tcnt_q, tcnt_nx;
    logic [PW-1:0]   ph_q, ph_nx;
    logic [CW-1:0]   pcnt_q, pcnt_nx;
    logic [CW-1:0]   last_pulse;

    assign last_pulse = wide_i ? CW'(NUM_WIDE - 1) : CW'(NUM_NARROW - 1);

    // next-state and counter logic
    always_comb begin
        state_nx = state_q;
        tcnt_nx  = tcnt_q;
        ph_nx    = ph_q;
        pcnt_nx  = pcnt_q;
        if (line_start_i) begin
            state_nx = ST_WAIT;
            tcnt_nx  = odd_next_i ? TW'(WAIT_ODD) : TW'(WAIT_EVEN);
            ph_nx    = '0;
            pcnt_nx  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_nx = ST_IDLE;
                end
                ST_WAIT: begin
                    if (tcnt_q == '0) begin
                        state_nx = ST_SETUP;
                        tcnt_nx  = TW'(HALF_CYC - 1);
                    end else begin
                        tcnt_nx = tcnt_q - 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (tcnt_q == '0) begin
                        state_nx = ST_BURST;
                        ph_nx    = '0;
                        pcnt_nx  = '0;
                    end else begin
                        tcnt_nx = tcnt_q - 1'b1;
                    end
                end
                ST_BURST: begin
                    if (ph_q == PW'(PERIOD - 1)) begin
                        ph_nx = '0;
                        if (pcnt_q == last_pulse) begin
                            state_nx = ST_IDLE;
                        end else begin
                            pcnt_nx = pcnt_q + 1'b1;
                        end
                    end else begin
                        ph_nx = ph_q + 1'b1;
                    end
                end
                default: begin
                    state_nx = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
            ph_q    <= '0;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_nx;
            tcnt_q  <= tcnt_nx;
            ph_q    <= ph_nx;
            pcnt_q  <= pcnt_nx;
        end
    end

    // output decode
    always_comb begin
        drive_o = '{hstart: 1'b0, hclk: 1'b0, blank: 1'b1};
        unique case (state_q)
            ST_IDLE, ST_WAIT: begin
                drive_o.blank = 1'b1;
            end
            ST_SETUP: begin
                drive_o.hstart = 1'b1;
            end
            ST_BURST: begin
                drive_o.blank = 1'b0;
                drive_o.hclk  = (ph_q < PW'(HALF_CYC));
            end
            default: begin
                drive_o.blank = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/htg_out_reg.sv
// Glitch-free registered pin drivers for the start pulse and the clock pair.
module htg_out_reg
    import htg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  htg_drive_t drive_i,
    output logic       hstart_o,
    output logic       hclk_a_o,
    output logic       hclk_b_o,
    output logic       hblank_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hstart_o <= 1'b0;
            hclk_a_o <= 1'b0;
            hclk_b_o <= 1'b1;
            hblank_o <= 1'b1;
        end else begin
            hstart_o <= drive_i.hstart;
            hclk_a_o <= drive_i.hclk;
            hclk_b_o <= ~drive_i.hclk;
            hblank_o <= drive_i.blank;
        end
    end

endmodule

// File: rtl/delta_htiming.sv
module delta_htiming
    import htg_pkg::*;
#(
    parameter int HALF_CYC   = 2,
    parameter int LEAD_CYC   = 6,
    parameter int NUM_WIDE   = 357,
    parameter int NUM_NARROW = 268
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start_i,
    input  logic aspect_wide_i,
    input  logic scan_fwd_i,
    output logic hstart_o,
    output logic hclk_a_o,
    output logic hclk_b_o,
    output logic hblank_o,
    output logic vid_inv_o,
    output logic aspect_wide_o,
    output logic scan_fwd_o
);

    logic       wide_l;
    logic       odd_next;
    htg_drive_t drive;

    htg_line_ctl u_line (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start_i  (line_start_i),
        .aspect_wide_i (aspect_wide_i),
        .scan_fwd_i    (scan_fwd_i),
        .wide_o        (wide_l),
        .fwd_o         (scan_fwd_o),
        .odd_o         (vid_inv_o),
        .odd_next_o    (odd_next)
    );

    htg_seq_fsm #(
        .HALF_CYC   (HALF_CYC),
        .LEAD_CYC   (LEAD_CYC),
        .NUM_WIDE   (NUM_WIDE),
        .NUM_NARROW (NUM_NARROW)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .odd_next_i   (odd_next),
        .wide_i       (wide_l),
        .drive_o      (drive)
    );

    htg_out_reg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_i  (drive),
        .hstart_o (hstart_o),
        .hclk_a_o (hclk_a_o),
        .hclk_b_o (hclk_b_o),
        .hblank_o (hblank_o)
    );

    assign aspect_wide_o = wide_l;

endmodule

// File: rtl/htg_checker.sv
module htg_checker (
    input logic clk,
    input logic rst_n,
    input logic line_start_i,
    input logic hstart_o,
    input logic hclk_a_o,
    input logic hclk_b_o,
    input logic hblank_o,
    input logic vid_inv_o,
    input logic aspect_wide_o,
    input logic scan_fwd_o
);

    AST_CLK_PAIR_COMPL: assert property (@(posedge clk) disable iff (!rst_n) hclk_b_o == !hclk_a_o); // R2
    AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) hblank_o |-> !hclk_a_o); // R2
    AST_START_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n) hstart_o |-> hblank_o); // R3
    AST_START_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n) ($fell(hstart_o) && !$past(line_start_i, 2)) |-> (hclk_a_o && !hblank_o)); // R3
    AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n) line_start_i |=> (vid_inv_o != $past(vid_inv_o))); // R7
    AST_POL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !line_start_i |=> $stable(vid_inv_o)); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !line_start_i |=> ($stable(aspect_wide_o) && $stable(scan_fwd_o))); // R8

endmodule

bind delta_htiming htg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_start_i  (line_start_i),
    .hstart_o      (hstart_o),
    .hclk_a_o      (hclk_a_o),
    .hclk_b_o      (hclk_b_o),
    .hblank_o      (hblank_o),
    .vid_inv_o     (vid_inv_o),
    .aspect_wide_o (aspect_wide_o),
    .scan_fwd_o    (scan_fwd_o)
);

// File: tb/delta_htiming_test.sv
module delta_htiming_test;

    localparam int HALF = 2;
    localparam int LEAD = 5;
    localparam int NW   = 7;
    localparam int NN   = 4;
    localparam int LLEN = 44;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0;
    logic asp_in = 1'b1;
    logic fwd_in = 1'b1;
    logic hstart, hclk_a, hclk_b, hblank, vid_inv, asp_out, fwd_out;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  exp_odd = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    delta_htiming #(
        .HALF_CYC   (HALF),
        .LEAD_CYC   (LEAD),
        .NUM_WIDE   (NW),
        .NUM_NARROW (NN)
    ) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start_i  (line_start),
        .aspect_wide_i (asp_in),
        .scan_fwd_i    (fwd_in),
        .hstart_o      (hstart),
        .hclk_a_o      (hclk_a),
        .hclk_b_o      (hclk_b),
        .hblank_o      (hblank),
        .vid_inv_o     (vid_inv),
        .aspect_wide_o (asp_out),
        .scan_fwd_o    (fwd_out)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at t=%0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
        end
    endtask

    // One line: strobe with the given modes, then compare LEN cycles against the model.
    task automatic run_line(input bit wid, input bit rgt, input int len, input bit mid_chg, input bit restart);
        int  k;
        int  n;
        bit  in_b, e_a, e_h;
        string tg;
        @(negedge clk);
        line_start = 1'b1;
        asp_in = wid;
        fwd_in = rgt;
        @(negedge clk);
        line_start = 1'b0;
        exp_odd = ~exp_odd;
        k = LEAD + (exp_odd ? 3 * HALF : 0);
        n = wid ? NW : NN;
        for (int j = 0; j < len; j++) begin
            in_b = (j >= k) && (j < k + 2 * HALF * n);
            e_a  = in_b && (((j - k) % (2 * HALF)) < HALF);
            e_h  = (j >= k - HALF) && (j < k);
            chk("R7", "vid_inv", vid_inv, exp_odd);
            chk("R8", "aspect_wide_o", asp_out, wid);
            chk("R8", "scan_fwd_o", fwd_out, rgt);
            chk("R2", "hclk_b", hclk_b, ~hclk_a);
            if (!(restart && j == 0)) begin
                if (restart) tg = "R9";
                else if (j < k + 2 * HALF) tg = "R4";
                else tg = wid ? "R5" : "R6";
                chk(tg, "hclk_a", hclk_a, e_a);
                chk(restart ? "R9" : "R3", "hstart", hstart, e_h);
                chk(restart ? "R9" : "R10", "hblank", hblank, ~in_b);
            end
            if (mid_chg && j == k + 3) begin
                asp_in = ~wid;
                fwd_in = ~rgt;
            end
            @(negedge clk);
        end
        asp_in = wid;
        fwd_in = rgt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "hstart", hstart, 1'b0);
        chk("R1", "hclk_a", hclk_a, 1'b0);
        chk("R1", "hclk_b", hclk_b, 1'b1);
        chk("R1", "hblank", hblank, 1'b1);
        chk("R1", "vid_inv", vid_inv, 1'b0);
        chk("R1", "aspect_wide_o", asp_out, 1'b1);
        chk("R1", "scan_fwd_o", fwd_out, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "hblank idle", hblank, 1'b1);

        // R4 R5 R6: all modes, each on both line parities
        for (int m = 0; m < 4; m++) begin
            run_line(m[1], m[0], LLEN, 1'b0, 1'b0);
            run_line(m[1], m[0], LLEN, 1'b0, 1'b0);
        end
        // R8: mode inputs flip mid-line on both parities
        run_line(1'b1, 1'b1, LLEN, 1'b1, 1'b0);
        run_line(1'b0, 1'b0, LLEN, 1'b1, 1'b0);
        run_line(1'b0, 1'b1, LLEN, 1'b1, 1'b0);
        // R9: strobe cuts into running bursts
        run_line(1'b1, 1'b0, LEAD + 9, 1'b0, 1'b0);
        run_line(1'b0, 1'b1, LLEN, 1'b0, 1'b1);
        run_line(1'b1, 1'b1, LEAD + 3 * HALF + 5, 1'b0, 1'b0);
        run_line(1'b1, 1'b0, LLEN, 1'b0, 1'b1);
        // back-to-back strobes right at burst end
        run_line(1'b1, 1'b1, LEAD + 2 * HALF * NW, 1'b0, 1'b0);
        run_line(1'b0, 1'b0, LLEN, 1'b0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule